// File: doc/BRIEF.md
# Oscillator Waveform Combiner

This block turns the state of one tone oscillator into a 12-bit waveform word. Each cycle it takes the 24-bit phase accumulator, a one-bit pulse level, a 12-bit noise word and a 4-bit waveform select. From these it builds triangle, sawtooth, pulse and noise shapes. The selected shapes are merged by bitwise AND, and the result is registered. A ring-modulation enable and the MSB of the sync-source oscillator can fold the triangle against a neighbouring voice.

When noise and pulse are both selected, a threshold rule replaces the plain AND result. A model input picks one of two rules. When no shape is selected, the output behaves like a floating node: it keeps its last value for a programmable number of cycles and then drops to zero. The block also flags two write-back paths for the oscillator core. One tells the noise register to absorb the output word. The other supplies a new accumulator MSB when sawtooth is combined with another shape. The upper 8 bits of the output serve as the oscillator readback value.

Select encoding: bit 0 triangle, bit 1 sawtooth, bit 2 pulse, bit 3 noise.

Top module: `wave_combiner`

## Requirements
- R1: With only sawtooth selected (sel = 4'b0010), the output one clock later equals accumulator bits 23:12.
- R2: With only triangle selected (sel = 4'b0001) and ring modulation off, the fold bit is accumulator bit 23. When the fold bit is 1, accumulator bits 22:12 are inverted. The output is {folded bits 22:12, 1'b0}.
- R3: With ring modulation enabled, the triangle fold bit becomes accumulator bit 23 XOR NOT sync-source MSB.
- R4: The pulse shape (sel bit 2) is 12'hFFF when the pulse level is 1 and 12'h000 when it is 0.
- R5: When several shapes are selected, the output is the bitwise AND of the selected shape words. The noise word is used unchanged.
- R6: With noise and pulse both selected and model = 0, let v be the AND result. The output is 0 if v < 12'hF00, else v & (v<<1) & (v<<2), truncated to 12 bits.
- R7: With noise and pulse both selected and model = 1, the output is v & (v<<1) if v < 12'hFC0, else 12'hFC0.
- R8: While sel = 0, the output holds its last value. After FADE_CYCLES consecutive clocks with sel = 0, the output is cleared to zero.
- R9: Any clock with a non-zero select reloads the fade timer, so a later idle period again holds the output for a full FADE_CYCLES clocks.
- R10: The noise write-back request is high in the cycle after the select value was greater than 8, and low otherwise.
- R11: With model = 0 and sawtooth selected together with any other shape, the accumulator-MSB write enable is high one clock later. The written value is accumulator bit 23 AND output bit 11. With model = 1, or in any other select case, the enable is low.
- R12: The readback port equals output bits 11:4.
- R13: After reset, the output, the readback, and both write-back signals are zero.
- R14: The output is registered: a change on the inputs appears at the output after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 24 | Phase accumulator |
| pulse_lvl_i | input | 1 | Pulse comparator level |
| noise_i | input | 12 | Noise word |
| sel_i | input | 4 | Waveform select: bit 3 noise, bit 2 pulse, bit 1 saw, bit 0 triangle |
| ring_en_i | input | 1 | Ring modulation enable |
| sync_msb_i | input | 1 | Sync-source accumulator MSB |
| model_i | input | 1 | Noise+pulse rule and accumulator write-back variant (0 or 1) |
| wave_o | output | 12 | Registered waveform word |
| osc_o | output | 8 | Readback, upper 8 bits of wave_o |
| noise_wb_o | output | 1 | Noise register write-back request |
| acc_msb_we_o | output | 1 | Accumulator MSB write enable |
| acc_msb_o | output | 1 | Accumulator MSB write value |

## Verification
Triangle values are tried on both sides of the fold, and with ring modulation under both sync-source MSB levels. This separates a missing inversion from an inverted ring term. Combined selections use bit patterns whose AND differs from each single shape. The noise-plus-pulse cases sit below and above each rule's threshold, and one case lies just under 12'hFC0, so rule A and rule B cannot be confused. The fade tests check the cycle just before expiry and the expiry cycle itself. They also idle again right after a short reselection, which shows that the timer reloads rather than keeps counting.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int unsigned ACC_W  = 24;
  localparam int unsigned WAVE_W = 12;
  localparam int unsigned SEL_W  = 4;

  localparam int unsigned SEL_TRI = 0;
  localparam int unsigned SEL_SAW = 1;
  localparam int unsigned SEL_PUL = 2;
  localparam int unsigned SEL_NOI = 3;

  typedef logic [WAVE_W-1:0] wave_t;

  typedef enum logic {
    MDL_A = 1'b0,
    MDL_B = 1'b1
  } model_e;

  localparam wave_t THR_A = 12'hF00;
  localparam wave_t THR_B = 12'hFC0;

  function automatic wave_t np_rule_a(input wave_t v);
    wave_t r;
    if (v < THR_A) r = '0;
    else           r = v & (v << 1) & (v << 2);
    return r;
  endfunction

  function automatic wave_t np_rule_b(input wave_t v);
    wave_t r;
    if (v < THR_B) r = v & (v << 1);
    else           r = THR_B;
    return r;
  endfunction
endpackage

// File: rtl/wc_shape.sv
module wc_shape
  import wc_pkg::*;
(
  input  logic [ACC_W-1:0] acc_i,
  input  logic             pulse_lvl_i,
  input  logic             ring_en_i,
  input  logic             sync_msb_i,
  output wave_t            tri_o,
  output wave_t            saw_o,
  output wave_t            pul_o
);
  localparam int unsigned TOP    = ACC_W - 1;
  localparam int unsigned LO     = ACC_W - WAVE_W;
  localparam int unsigned FOLD_W = WAVE_W - 1;

  logic              fold_msb;
  logic [FOLD_W-1:0] fold_bits;

  // ring term replaces the fold bit with msb ^ ~sync
  assign fold_msb  = acc_i[TOP] ^ (ring_en_i & ~sync_msb_i);
  assign fold_bits = acc_i[TOP-1:LO] ^ {FOLD_W{fold_msb}};

  assign tri_o = {fold_bits, 1'b0};
  assign saw_o = acc_i[TOP:LO];
  assign pul_o = {WAVE_W{pulse_lvl_i}};
endmodule

// File: rtl/wc_mix.sv
module wc_mix
  import wc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  model_e           model_i,
  input  wave_t            tri_i,
  input  wave_t            saw_i,
  input  wave_t            pul_i,
  input  wave_t            noise_i,
  output wave_t            mix_o
);
  wave_t shapes [SEL_W];
  wave_t and_v;

  assign shapes[SEL_TRI] = tri_i;
  assign shapes[SEL_SAW] = saw_i;
  assign shapes[SEL_PUL] = pul_i;
  assign shapes[SEL_NOI] = noise_i;

  always_comb begin
    and_v = '1;
    for (int i = 0; i < SEL_W; i++) begin
      if (sel_i[i]) and_v &= shapes[i];
    end
  end

  always_comb begin
    mix_o = and_v;
    if (sel_i[SEL_NOI] && sel_i[SEL_PUL]) begin
      if (model_i == MDL_A) mix_o = np_rule_a(and_v);
      else                  mix_o = np_rule_b(and_v);
    end
  end

  // R6
  rule_a_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[SEL_NOI] && sel_i[SEL_PUL] && model_i == MDL_A && mix_o != '0)
      |-> (and_v >= THR_A));

  // R7
  rule_b_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[SEL_NOI] && sel_i[SEL_PUL] && model_i == MDL_B) |-> (mix_o <= THR_B));
endmodule

// File: rtl/wc_hold.sv
module wc_hold
  import wc_pkg::*;
#(
  parameter int unsigned FADE_CYCLES = 64
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sel_any_i,
  input  wave_t mix_i,
  output wave_t wave_o
);
  localparam int unsigned CNT_W = $clog2(FADE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FADE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  wave_t            wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wave_q <= '0;
    end else if (sel_any_i) begin
      cnt_q  <= CNT_MAX;
      wave_q <= mix_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) wave_q <= '0;
    end
  end

  assign wave_o = wave_q;

  // R8
  fade_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_any_i && cnt_q != CNT_ONE) |=> $stable(wave_q));

  // R8
  fade_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_any_i && cnt_q == CNT_ONE) |=> (wave_q == '0));

  // R9
  fade_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_any_i |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/wave_combiner.sv
module wave_combiner
  import wc_pkg::*;
#(
  parameter int unsigned FADE_CYCLES = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [23:0] acc_i,
  input  logic        pulse_lvl_i,
  input  logic [11:0] noise_i,
  input  logic [3:0]  sel_i,
  input  logic        ring_en_i,
  input  logic        sync_msb_i,
  input  logic        model_i,
  output logic [11:0] wave_o,
  output logic [7:0]  osc_o,
  output logic        noise_wb_o,
  output logic        acc_msb_we_o,
  output logic        acc_msb_o
);
  localparam int unsigned OSC_W = 8;
  localparam logic [SEL_W-1:0] WB_MIN = SEL_W'(8);
  localparam logic [SEL_W-1:0] NOT_SAW = ~(SEL_W'(1) << SEL_SAW);

  wave_t  tri_w, saw_w, pul_w, mix_w, wave_w;
  model_e model_w;
  logic   amsb_we_d, amsb_d;
  logic   wb_q, amsb_we_q, amsb_q;

  assign model_w = model_e'(model_i);

  wc_shape u_shape (
    .acc_i       (acc_i),
    .pulse_lvl_i (pulse_lvl_i),
    .ring_en_i   (ring_en_i),
    .sync_msb_i  (sync_msb_i),
    .tri_o       (tri_w),
    .saw_o       (saw_w),
    .pul_o       (pul_w)
  );

  wc_mix u_mix (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .model_i (model_w),
    .tri_i   (tri_w),
    .saw_i   (saw_w),
    .pul_i   (pul_w),
    .noise_i (noise_i),
    .mix_o   (mix_w)
  );

  wc_hold #(.FADE_CYCLES(FADE_CYCLES)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_any_i (sel_i != '0),
    .mix_i     (mix_w),
    .wave_o    (wave_w)
  );

  // saw shorted with another shape can pull the accumulator top bit low
  assign amsb_we_d = (model_w == MDL_A) && sel_i[SEL_SAW] && ((sel_i & NOT_SAW) != '0);
  assign amsb_d    = amsb_we_d & acc_i[ACC_W-1] & mix_w[WAVE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_q      <= 1'b0;
      amsb_we_q <= 1'b0;
      amsb_q    <= 1'b0;
    end else begin
      wb_q      <= (sel_i > WB_MIN);
      amsb_we_q <= amsb_we_d;
      amsb_q    <= amsb_d;
    end
  end

  assign wave_o       = wave_w;
  assign osc_o        = wave_w[WAVE_W-1 -: OSC_W];
  assign noise_wb_o   = wb_q;
  assign acc_msb_we_o = amsb_we_q;
  assign acc_msb_o    = amsb_q;

  // R10
  wb_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i > WB_MIN) |=> noise_wb_o);

  // R10
  wb_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i <= WB_MIN) |=> !noise_wb_o);

  // R11
  amsb_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_msb_o |-> (acc_msb_we_o && wave_o[WAVE_W-1]));

  // R11
  amsb_model_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (model_i == 1'b1) |=> !acc_msb_we_o);
endmodule

// File: tb/sim_wave_combiner.sv
`timescale 1ns/1ps
module sim_wave_combiner;
  localparam int FADE = 64;

  typedef struct packed {
    logic [23:0] acc;
    logic        pul;
    logic [11:0] noi;
    logic [3:0]  sel;
    logic        ring;
    logic        sync;
    logic        mdl;
    logic [11:0] exp_w;
    logic        wb;
    logic        awe;
    logic        amv;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{24'hABC123, 1'b0, 12'h000, 4'h2, 1'b0, 1'b0, 1'b0, 12'hABC, 1'b0, 1'b0, 1'b0}, // R1
    '{24'h3A5000, 1'b0, 12'h000, 4'h1, 1'b0, 1'b0, 1'b0, 12'h74A, 1'b0, 1'b0, 1'b0}, // R2
    '{24'hC12000, 1'b0, 12'h000, 4'h1, 1'b0, 1'b0, 1'b0, 12'h7DA, 1'b0, 1'b0, 1'b0}, // R2
    '{24'h3A5000, 1'b0, 12'h000, 4'h1, 1'b1, 1'b0, 1'b0, 12'h8B4, 1'b0, 1'b0, 1'b0}, // R3
    '{24'h3A5000, 1'b0, 12'h000, 4'h1, 1'b1, 1'b1, 1'b0, 12'h74A, 1'b0, 1'b0, 1'b0}, // R3
    '{24'h000000, 1'b1, 12'h000, 4'h4, 1'b0, 1'b0, 1'b0, 12'hFFF, 1'b0, 1'b0, 1'b0}, // R4
    '{24'hFFF000, 1'b0, 12'h000, 4'h4, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0}, // R4
    '{24'h000000, 1'b0, 12'h5A0, 4'h8, 1'b0, 1'b0, 1'b0, 12'h5A0, 1'b0, 1'b0, 1'b0}, // R5
    '{24'h3A5000, 1'b0, 12'h000, 4'h3, 1'b0, 1'b0, 1'b0, 12'h300, 1'b0, 1'b1, 1'b0}, // R5
    '{24'hABC123, 1'b1, 12'h000, 4'h6, 1'b0, 1'b0, 1'b0, 12'hABC, 1'b0, 1'b1, 1'b1}, // R5
    '{24'h000000, 1'b1, 12'hFF0, 4'hC, 1'b0, 1'b0, 1'b0, 12'hFC0, 1'b1, 1'b0, 1'b0}, // R6
    '{24'h000000, 1'b1, 12'hEF0, 4'hC, 1'b0, 1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0}, // R6
    '{24'h000000, 1'b1, 12'hFF0, 4'hC, 1'b0, 1'b0, 1'b1, 12'hFC0, 1'b1, 1'b0, 1'b0}, // R7
    '{24'h000000, 1'b1, 12'h5A0, 4'hC, 1'b0, 1'b0, 1'b1, 12'h100, 1'b1, 1'b0, 1'b0}, // R7
    '{24'h000000, 1'b1, 12'hFBF, 4'hC, 1'b0, 1'b0, 1'b1, 12'hF3E, 1'b1, 1'b0, 1'b0}, // R7
    '{24'h000000, 1'b0, 12'hFFF, 4'hC, 1'b0, 1'b0, 1'b1, 12'h000, 1'b1, 1'b0, 1'b0}, // R7
    '{24'hC12000, 1'b0, 12'h000, 4'h3, 1'b0, 1'b0, 1'b0, 12'h412, 1'b0, 1'b1, 1'b0}, // R11
    '{24'hABC123, 1'b1, 12'h000, 4'h6, 1'b0, 1'b0, 1'b1, 12'hABC, 1'b0, 1'b0, 1'b0}, // R11
    '{24'hABC000, 1'b0, 12'hFF0, 4'hA, 1'b0, 1'b0, 1'b0, 12'hAB0, 1'b1, 1'b1, 1'b1}, // R10
    '{24'h3A5000, 1'b0, 12'h000, 4'h5, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0}  // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] acc = '0;
  logic        pul = 1'b0;
  logic [11:0] noi = '0;
  logic [3:0]  sel = '0;
  logic        ring = 1'b0;
  logic        sync = 1'b0;
  logic        mdl = 1'b0;
  logic [11:0] wave;
  logic [7:0]  osc;
  logic        wb, awe, amv;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wave_combiner #(.FADE_CYCLES(FADE)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .acc_i        (acc),
    .pulse_lvl_i  (pul),
    .noise_i      (noi),
    .sel_i        (sel),
    .ring_en_i    (ring),
    .sync_msb_i   (sync),
    .model_i      (mdl),
    .wave_o       (wave),
    .osc_o        (osc),
    .noise_wb_o   (wb),
    .acc_msb_we_o (awe),
    .acc_msb_o    (amv)
  );

  task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic string vtag(input int i);
    if (i == 0) return "R1";
    if (i <= 2) return "R2";
    if (i <= 4) return "R3";
    if (i <= 6) return "R4";
    if (i <= 9 || i == 19) return "R5";
    if (i <= 11) return "R6";
    if (i <= 15) return "R7";
    if (i <= 17) return "R11";
    return "R10";
  endfunction

  // drive at negedge, sample 1 ns after the next rising edge
  task automatic step(input logic [23:0] a, input logic [3:0] s);
    @(negedge clk);
    acc = a;
    sel = s;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #12;
    // R13 reset state
    chk("R13 wave", 24'(wave), 24'h0);
    chk("R13 osc", 24'(osc), 24'h0);
    chk("R13 wb", 24'(wb), 24'h0);
    chk("R13 awe", 24'(awe), 24'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R14: value stays until the rising edge
    @(negedge clk);
    acc = 24'h5A5000;
    sel = 4'h2;
    #1;
    chk("R14 before edge", 24'(wave), 24'h0);
    @(posedge clk);
    #1;
    chk("R14 after edge", 24'(wave), 24'h5A5);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc  = VECS[i].acc;
      pul  = VECS[i].pul;
      noi  = VECS[i].noi;
      ring = VECS[i].ring;
      sync = VECS[i].sync;
      mdl  = VECS[i].mdl;
      sel  = VECS[i].sel;
      @(posedge clk);
      #1;
      chk({vtag(i), " wave"}, 24'(wave), 24'(VECS[i].exp_w));
      chk("R12 osc", 24'(osc), 24'(VECS[i].exp_w[11:4]));
      chk("R10 wb", 24'(wb), 24'(VECS[i].wb));
      chk("R11 awe", 24'(awe), 24'(VECS[i].awe));
      chk("R11 amv", 24'(amv), 24'(VECS[i].amv));
    end

    // R8: hold for FADE-1 idle clocks, clear on the FADE-th
    ring = 0; pul = 0; noi = '0; mdl = 0;
    step(24'hABC000, 4'h2);
    chk("R8 setup", 24'(wave), 24'hABC);
    for (int k = 1; k < FADE; k++) step(24'h000000, 4'h0);
    chk("R8 hold", 24'(wave), 24'hABC);
    chk("R10 idle wb", 24'(wb), 24'h0);
    chk("R11 idle awe", 24'(awe), 24'h0);
    step(24'h000000, 4'h0);
    chk("R8 clear", 24'(wave), 24'h0);
    step(24'h000000, 4'h0);
    chk("R8 stays clear", 24'(wave), 24'h0);

    // R9: reselect restarts the timer
    step(24'h123000, 4'h2);
    for (int k = 0; k < 10; k++) step(24'h000000, 4'h0);
    chk("R9 mid hold", 24'(wave), 24'h123);
    step(24'h456000, 4'h2);
    for (int k = 1; k < FADE; k++) step(24'h000000, 4'h0);
    chk("R9 reload hold", 24'(wave), 24'h456);
    step(24'h000000, 4'h0);
    chk("R9 reload clear", 24'(wave), 24'h0);

    // R13 asynchronous reset mid-run
    step(24'hFFF000, 4'hA);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R13 async wave", 24'(wave), 24'h0);
    chk("R13 async wb", 24'(wb), 24'h0);
    rst_n = 1'b1;

    finish_run();
  end
endmodule